// File: doc/BRIEF.md
# Tile Delta Color Compressor

This block compresses an 8x8 tile of 32-bit RGBA pixels (four 8-bit channels) without loss. Pixels arrive one per cycle in raster order over a valid/ready input. Once the 64th pixel has been taken, the block chooses the densest encoding that the tile allows. It then streams the result as 32-bit words over a valid/ready output. Every word carries the 2-bit mode code, and the final word is flagged.

Each delta encoding stores the first pixel in full as an anchor. Every later pixel is stored as a signed per-channel difference from a neighbor: the pixel to its left, or the pixel above when it starts a row. A tile whose 2x2 quads each hold four identical pixels can first be collapsed to a 4x4 grid of quad samples, and that grid is then delta-coded. If no delta encoding fits, the tile goes out raw, so nothing is ever lost. The input is held off from the cycle after the last pixel until the final output word has been accepted.

Top module: `tile_delta_compressor`

## Requirements
- R1: After reset, `inReady` is 1 and `outValid` is 0.
- R2: The block accepts exactly 64 pixels per tile. `inReady` is 0 from the cycle after the 64th pixel is accepted until the final output word has been accepted, and it is 1 again right after that word.
- R3: If all 16 quads are constant and every quad-grid delta fits in signed 4 bits per channel, the mode is 2'b11 and the payload is 9 words. This mode takes priority even when another mode would also fit.
- R4: Otherwise, if every pixel delta fits in signed 2 bits per channel (range -2..+1), the mode is 2'b10 and the payload is 17 words.
- R5: Otherwise, if every pixel delta fits in signed 4 bits per channel (range -8..+7), the mode is 2'b01 and the payload is 33 words.
- R6: Otherwise the mode is 2'b00, the payload is 64 words, and word i is pixel i unchanged.
- R7: A delta is the current value minus the neighbor value, modulo 256, per channel. The neighbor is the left pixel, or the pixel above for column 0. The quad grid uses the same rule, with the sample of a quad being its top-left pixel.
- R8: Payload bits are packed LSB first. Word 0 bits 31:0 hold the anchor. The delta groups then follow in raster order, each group holding channels 0..3 low to high (channel c is pixel bits 8c+7:8c), with no gaps. Bits past the last field in the final word are 0.
- R9: While `outValid` is high and `outReady` is low, `outData`, `outMode` and `outLast` hold their values. `outMode` is the same on every word of a tile, and `outLast` is high on the final word only.
- R10: Decoding the payload with the rules in R6 to R8 gives back the input tile exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel is valid |
| inReady | output | 1 | Block can take a pixel |
| inPixel | input | 32 | Pixel, channel c in bits 8c+7:8c |
| outValid | output | 1 | Output word is valid |
| outReady | input | 1 | Consumer takes the word |
| outMode | output | 2 | Encoding of the current tile |
| outData | output | 32 | Payload word |
| outLast | output | 1 | Final word of the tile |

## Verification
The hardest cases to reach are tiles that sit exactly on a budget edge: a single delta of +1, -2, +7 or -8 against one of +2 or +8, a single odd pixel breaking one quad, and a row start whose left neighbor in memory order would give a large delta while the pixel above gives zero. The stimulus starts from a flat tile and sweeps a lone disturbance from -9 to +9 through every channel. It places that disturbance at the anchor, at a column-0 pixel, mid-row and at the final pixel. The mode each tile should get comes from an arithmetic model in the bench, and the returned payload is decoded and compared pixel by pixel. Tiles are drained alternately at full rate and under pseudo-random backpressure.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  typedef enum logic [1:0] {
    MODE_RAW     = 2'b00,
    MODE_HALF    = 2'b01,
    MODE_QUARTER = 2'b10,
    MODE_EIGHTH  = 2'b11
  } tdcMode_e;

  typedef enum logic [1:0] {
    ST_COLLECT,
    ST_DECIDE,
    ST_EMIT
  } tdcState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic decide;
    logic emitting;
  } tdcCtrl_t;

  function automatic int wordsFor(input int bits, input int wordW);
    return (bits + wordW - 1) / wordW;
  endfunction

  // true when the low chBits of d, read as two's complement, survive truncation to w bits
  function automatic logic fitsSigned(input logic [31:0] d, input int chBits, input int w);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < chBits; b++) begin
      if (b >= w - 1 && d[b] != d[w-1]) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/tdc_control.sv
module tdc_control
  import tdc_pkg::*;
#(
  parameter int NUM_PIX       = 64,
  parameter int WORDS_RAW     = 64,
  parameter int WORDS_HALF    = 33,
  parameter int WORDS_QUARTER = 17,
  parameter int WORDS_EIGHTH  = 9,
  localparam int PIX_IDX_W    = $clog2(NUM_PIX),
  localparam int WORD_IDX_W   = $clog2(WORDS_RAW)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic                  outReady,
  output logic                  outValid,
  output logic                  outLast,
  input  tdcMode_e              chosenMode,
  output tdcCtrl_t              ctrl,
  output logic [PIX_IDX_W-1:0]  wrIdx,
  output logic [WORD_IDX_W-1:0] wordIdx
);

  tdcState_e             state;
  logic [PIX_IDX_W-1:0]  pixCnt;
  logic [WORD_IDX_W-1:0] wordCnt;
  logic [WORD_IDX_W-1:0] lastWord;

  always_comb begin
    case (chosenMode)
      MODE_HALF:    lastWord = WORD_IDX_W'(WORDS_HALF - 1);
      MODE_QUARTER: lastWord = WORD_IDX_W'(WORDS_QUARTER - 1);
      MODE_EIGHTH:  lastWord = WORD_IDX_W'(WORDS_EIGHTH - 1);
      default:      lastWord = WORD_IDX_W'(WORDS_RAW - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_COLLECT;
      pixCnt  <= '0;
      wordCnt <= '0;
    end else begin
      case (state)
        ST_COLLECT: if (inValid) begin
          if (pixCnt == PIX_IDX_W'(NUM_PIX - 1)) begin
            pixCnt <= '0;
            state  <= ST_DECIDE;
          end else begin
            pixCnt <= pixCnt + 1'b1;
          end
        end
        ST_DECIDE: begin
          wordCnt <= '0;
          state   <= ST_EMIT;
        end
        ST_EMIT: if (outReady) begin
          if (wordCnt == lastWord) state <= ST_COLLECT;
          else wordCnt <= wordCnt + 1'b1;
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end

  assign inReady       = (state == ST_COLLECT);
  assign outValid      = (state == ST_EMIT);
  assign outLast       = outValid && (wordCnt == lastWord);
  assign ctrl.capture  = inReady && inValid;
  assign ctrl.decide   = (state == ST_DECIDE);
  assign ctrl.emitting = outValid;
  assign wrIdx         = pixCnt;
  assign wordIdx       = wordCnt;

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.capture && pixCnt == PIX_IDX_W'(NUM_PIX - 1)) |=> !inReady);

  // R2
  last_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outReady && outLast) |=> (inReady && !outValid));

endmodule

// File: rtl/tdc_datapath.sv
module tdc_datapath
  import tdc_pkg::*;
#(
  parameter int TILE_DIM   = 8,
  parameter int CH_BITS    = 8,
  parameter int CHANNELS   = 4,
  parameter int HALF_W     = 4,
  parameter int QUARTER_W  = 2,
  parameter int WORD_W     = 32,
  localparam int PIX_W     = CH_BITS * CHANNELS,
  localparam int NUM_PIX   = TILE_DIM * TILE_DIM,
  localparam int QDIM      = TILE_DIM / 2,
  localparam int NUM_QUAD  = QDIM * QDIM,
  localparam int RAW_TOT   = NUM_PIX * PIX_W,
  localparam int HALF_TOT  = PIX_W + (NUM_PIX - 1) * CHANNELS * HALF_W,
  localparam int QUART_TOT = PIX_W + (NUM_PIX - 1) * CHANNELS * QUARTER_W,
  localparam int EIGHT_TOT = PIX_W + (NUM_QUAD - 1) * CHANNELS * HALF_W,
  localparam int WORDS_RAW = wordsFor(RAW_TOT, WORD_W),
  localparam int STREAM_W  = WORDS_RAW * WORD_W,
  localparam int PIX_IDX_W = $clog2(NUM_PIX),
  localparam int WORD_IDX_W = $clog2(WORDS_RAW)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  tdcCtrl_t              ctrl,
  input  logic [PIX_IDX_W-1:0]  wrIdx,
  input  logic [WORD_IDX_W-1:0] wordIdx,
  input  logic [PIX_W-1:0]      inPixel,
  output tdcMode_e              chosenMode,
  output logic [WORD_W-1:0]     outWord
);

  logic [PIX_W-1:0] pixBuf [NUM_PIX];

  always_ff @(posedge clk) begin
    if (ctrl.capture) pixBuf[wrIdx] <= inPixel;
  end

  logic [NUM_PIX-1:0]  okHalf, okQuarter;
  logic [NUM_QUAD-1:0] quadConst, gridOk;
  logic [STREAM_W-1:0] packRaw, packHalf, packQuarter, packEighth;

  assign okHalf[0]    = 1'b1;
  assign okQuarter[0] = 1'b1;
  assign gridOk[0]    = 1'b1;

  assign packHalf[PIX_W-1:0]    = pixBuf[0];
  assign packQuarter[PIX_W-1:0] = pixBuf[0];
  assign packEighth[PIX_W-1:0]  = pixBuf[0];
  assign packHalf[STREAM_W-1:HALF_TOT]    = '0;
  assign packQuarter[STREAM_W-1:QUART_TOT] = '0;
  assign packEighth[STREAM_W-1:EIGHT_TOT]  = '0;

  for (genvar p = 0; p < NUM_PIX; p++) begin : g_raw
    assign packRaw[p*PIX_W +: PIX_W] = pixBuf[p];
  end
  if (STREAM_W > RAW_TOT) begin : g_rawTail
    assign packRaw[STREAM_W-1:RAW_TOT] = '0;
  end

  // per-pixel deltas against the left neighbor, or the one above at a row start
  for (genvar p = 1; p < NUM_PIX; p++) begin : g_pix
    localparam int NB = (p % TILE_DIM == 0) ? p - TILE_DIM : p - 1;
    logic [CHANNELS-1:0] chHalf, chQuarter;
    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
      logic [CH_BITS-1:0] diff;
      assign diff = pixBuf[p][c*CH_BITS +: CH_BITS] - pixBuf[NB][c*CH_BITS +: CH_BITS];
      assign chHalf[c]    = fitsSigned(32'(diff), CH_BITS, HALF_W);
      assign chQuarter[c] = fitsSigned(32'(diff), CH_BITS, QUARTER_W);
      assign packHalf[PIX_W + ((p-1)*CHANNELS + c)*HALF_W +: HALF_W] = diff[HALF_W-1:0];
      assign packQuarter[PIX_W + ((p-1)*CHANNELS + c)*QUARTER_W +: QUARTER_W] =
        diff[QUARTER_W-1:0];
    end
    assign okHalf[p]    = &chHalf;
    assign okQuarter[p] = &chQuarter;
  end

  // constant-quad detection and deltas on the collapsed grid
  for (genvar q = 0; q < NUM_QUAD; q++) begin : g_quad
    localparam int QR   = q / QDIM;
    localparam int QC   = q % QDIM;
    localparam int BASE = 2*QR*TILE_DIM + 2*QC;
    assign quadConst[q] = (pixBuf[BASE] == pixBuf[BASE+1]) &&
                          (pixBuf[BASE] == pixBuf[BASE+TILE_DIM]) &&
                          (pixBuf[BASE] == pixBuf[BASE+TILE_DIM+1]);
    if (q > 0) begin : g_grid
      localparam int NQ    = (QC == 0) ? q - QDIM : q - 1;
      localparam int NBASE = 2*(NQ / QDIM)*TILE_DIM + 2*(NQ % QDIM);
      logic [CHANNELS-1:0] chGrid;
      for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        logic [CH_BITS-1:0] diff;
        assign diff = pixBuf[BASE][c*CH_BITS +: CH_BITS] - pixBuf[NBASE][c*CH_BITS +: CH_BITS];
        assign chGrid[c] = fitsSigned(32'(diff), CH_BITS, HALF_W);
        assign packEighth[PIX_W + ((q-1)*CHANNELS + c)*HALF_W +: HALF_W] = diff[HALF_W-1:0];
      end
      assign gridOk[q] = &chGrid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chosenMode <= MODE_RAW;
    end else if (ctrl.decide) begin
      if (&quadConst && &gridOk) chosenMode <= MODE_EIGHTH;
      else if (&okQuarter)       chosenMode <= MODE_QUARTER;
      else if (&okHalf)          chosenMode <= MODE_HALF;
      else                       chosenMode <= MODE_RAW;
    end
  end

  logic [STREAM_W-1:0] stream;
  always_comb begin
    case (chosenMode)
      MODE_HALF:    stream = packHalf;
      MODE_QUARTER: stream = packQuarter;
      MODE_EIGHTH:  stream = packEighth;
      default:      stream = packRaw;
    endcase
  end

  assign outWord = stream[wordIdx*WORD_W +: WORD_W];

  // R3
  eighth_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.emitting && chosenMode == MODE_EIGHTH) |-> (&quadConst));

endmodule

// File: rtl/tile_delta_compressor.sv
module tile_delta_compressor
  import tdc_pkg::*;
#(
  parameter int TILE_DIM  = 8,
  parameter int CH_BITS   = 8,
  parameter int CHANNELS  = 4,
  parameter int HALF_W    = 4,
  parameter int QUARTER_W = 2,
  parameter int WORD_W    = 32,
  localparam int PIX_W    = CH_BITS * CHANNELS,
  localparam int NUM_PIX  = TILE_DIM * TILE_DIM,
  localparam int NUM_QUAD = (TILE_DIM / 2) * (TILE_DIM / 2),
  localparam int WORDS_RAW     = wordsFor(NUM_PIX * PIX_W, WORD_W),
  localparam int WORDS_HALF    = wordsFor(PIX_W + (NUM_PIX - 1) * CHANNELS * HALF_W, WORD_W),
  localparam int WORDS_QUARTER = wordsFor(PIX_W + (NUM_PIX - 1) * CHANNELS * QUARTER_W, WORD_W),
  localparam int WORDS_EIGHTH  = wordsFor(PIX_W + (NUM_QUAD - 1) * CHANNELS * HALF_W, WORD_W),
  localparam int PIX_IDX_W  = $clog2(NUM_PIX),
  localparam int WORD_IDX_W = $clog2(WORDS_RAW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  output logic              inReady,
  input  logic [PIX_W-1:0]  inPixel,
  output logic              outValid,
  input  logic              outReady,
  output logic [1:0]        outMode,
  output logic [WORD_W-1:0] outData,
  output logic              outLast
);

  tdcCtrl_t              ctrl;
  tdcMode_e              chosenMode;
  logic [PIX_IDX_W-1:0]  wrIdx;
  logic [WORD_IDX_W-1:0] wordIdx;

  tdc_control #(
    .NUM_PIX(NUM_PIX), .WORDS_RAW(WORDS_RAW), .WORDS_HALF(WORDS_HALF),
    .WORDS_QUARTER(WORDS_QUARTER), .WORDS_EIGHTH(WORDS_EIGHTH)
  ) i_control (
    .clk, .rst_n, .inValid, .inReady, .outReady, .outValid, .outLast,
    .chosenMode, .ctrl, .wrIdx, .wordIdx
  );

  tdc_datapath #(
    .TILE_DIM(TILE_DIM), .CH_BITS(CH_BITS), .CHANNELS(CHANNELS),
    .HALF_W(HALF_W), .QUARTER_W(QUARTER_W), .WORD_W(WORD_W)
  ) i_datapath (
    .clk, .rst_n, .ctrl, .wrIdx, .wordIdx, .inPixel, .chosenMode, .outWord(outData)
  );

  assign outMode = chosenMode;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outMode) && $stable(outLast)));

  // R9
  mode_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && $past(outValid)) |-> $stable(outMode));

endmodule

// File: tb/test_tile_delta_compressor.sv
module test_tile_delta_compressor;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        inValid, inReady, outValid, outReady, outLast;
  logic [31:0] inPixel, outData;
  logic [1:0]  outMode;

  always #10 clk = ~clk;

  tile_delta_compressor i_tile_delta_compressor (
    .clk, .rst_n, .inValid, .inReady, .inPixel,
    .outValid, .outReady, .outMode, .outData, .outLast
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [31:0]   tile [64];
  logic [2047:0] rx;
  logic [15:0]   lfsr = 16'hACE1;
  logic [31:0]   noise = 32'h1234_5678;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nbrOf(input int i, input int dim);
    return (i % dim == 0) ? i - dim : i - 1;
  endfunction

  function automatic bit fitsB(input logic [7:0] a, input logic [7:0] b, input int w);
    int d;
    d = int'(a) - int'(b);
    if (d > 127) d -= 256;
    if (d < -128) d += 256;
    return (d >= -(1 << (w-1))) && (d < (1 << (w-1)));
  endfunction

  function automatic int quadPix(input int g);
    return 2*(g/4)*8 + 2*(g%4);
  endfunction

  // expected mode code from R3..R7
  function automatic int expMode();
    bit allConst = 1, gridFit = 1, fit2 = 1, fit4 = 1;
    for (int g = 0; g < 16; g++) begin
      int p = quadPix(g);
      if (tile[p] != tile[p+1] || tile[p] != tile[p+8] || tile[p] != tile[p+9]) allConst = 0;
      if (g > 0)
        for (int ch = 0; ch < 4; ch++)
          if (!fitsB(tile[p][ch*8 +: 8], tile[quadPix(nbrOf(g,4))][ch*8 +: 8], 4)) gridFit = 0;
    end
    for (int i = 1; i < 64; i++)
      for (int ch = 0; ch < 4; ch++) begin
        if (!fitsB(tile[i][ch*8 +: 8], tile[nbrOf(i,8)][ch*8 +: 8], 2)) fit2 = 0;
        if (!fitsB(tile[i][ch*8 +: 8], tile[nbrOf(i,8)][ch*8 +: 8], 4)) fit4 = 0;
      end
    if (allConst && gridFit) return 3;
    if (fit2) return 2;
    if (fit4) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] sx(input logic [3:0] f, input int w);
    int v;
    v = int'(f) & ((1 << w) - 1);
    if (v >= (1 << (w-1))) v -= (1 << w);
    return 8'(v);
  endfunction

  // independent decoder of the received payload (R6, R7, R8)
  function automatic int decodeMismatches(input int mode);
    logic [31:0] dec [64];
    logic [31:0] grid [16];
    int pos, w, bad;
    bad = 0;
    if (mode == 0) begin
      for (int i = 0; i < 64; i++) dec[i] = rx[i*32 +: 32];
    end else if (mode == 3) begin
      grid[0] = rx[31:0];
      pos = 32;
      for (int g = 1; g < 16; g++)
        for (int ch = 0; ch < 4; ch++) begin
          grid[g][ch*8 +: 8] = grid[nbrOf(g,4)][ch*8 +: 8] + sx(rx[pos +: 4], 4);
          pos += 4;
        end
      for (int i = 0; i < 64; i++) dec[i] = grid[((i/8)/2)*4 + (i%8)/2];
    end else begin
      w = (mode == 2) ? 2 : 4;
      dec[0] = rx[31:0];
      pos = 32;
      for (int i = 1; i < 64; i++)
        for (int ch = 0; ch < 4; ch++) begin
          dec[i][ch*8 +: 8] = dec[nbrOf(i,8)][ch*8 +: 8] + sx(rx[pos +: 4], w);
          pos += w;
        end
    end
    for (int i = 0; i < 64; i++) if (dec[i] !== tile[i]) bad++;
    return bad;
  endfunction

  task automatic sendTile();
    for (int i = 0; i < 64; i++) begin
      while (!inReady) @(negedge clk);
      inValid = 1'b1;
      inPixel = tile[i];
      @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  task automatic runTile(input bit bp, input string name);
    int em, n, readyBad, holdBad, modeBad, firstMode, tailBad;
    int wordsExp [4] = '{64, 33, 17, 9};
    int bitsExp [4]  = '{2048, 1040, 536, 272};
    bit done, prevStall, readyAfter;
    logic [31:0] prevData;
    logic [1:0]  prevMode;
    string rq;
    em = expMode();
    rx = '0;
    sendTile();
    readyAfter = inReady;
    n = 0; readyBad = 0; holdBad = 0; modeBad = 0; firstMode = -1;
    done = 0; prevStall = 0; prevData = '0; prevMode = '0;
    while (!done) begin
      outReady = bp ? lfsr[0] : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (outValid) begin
        if (inReady) readyBad++;
        if (prevStall && (outData !== prevData || outMode !== prevMode)) holdBad++;
        if (firstMode < 0) firstMode = int'(outMode);
        else if (int'(outMode) != firstMode) modeBad++;
        if (outReady) begin
          if (n < 64) rx[n*32 +: 32] = outData;
          n++;
          if (outLast) done = 1;
        end
        prevStall = !outReady;
        prevData  = outData;
        prevMode  = outMode;
      end
      @(negedge clk);
    end
    outReady = 1'b0;
    rq = (em == 3) ? "R3" : (em == 2) ? "R4" : (em == 1) ? "R5" : "R6";
    check(int'(firstMode) == em, {rq, " mode ", name}, firstMode, em);
    // R8 word count, R9 outLast only on the final word
    check(n == wordsExp[em], {"R8 R9 word count ", name}, n, wordsExp[em]);
    tailBad = 0;
    for (int b = bitsExp[em]; b < wordsExp[em]*32; b++) if (rx[b] !== 1'b0) tailBad++;
    check(tailBad == 0, {"R8 zero fill ", name}, tailBad, 0);
    // R10 and R7: decode with the neighbor rule and compare
    check(decodeMismatches(firstMode < 0 ? 0 : firstMode) == 0, {"R10 R7 round trip ", name},
          decodeMismatches(firstMode < 0 ? 0 : firstMode), 0);
    check(!readyAfter && readyBad == 0, {"R2 input held off ", name}, readyBad + int'(readyAfter), 0);
    check(inReady === 1'b1, {"R2 ready after last word ", name}, inReady, 1);
    check(holdBad == 0 && modeBad == 0, {"R9 hold and mode ", name}, holdBad + modeBad, 0);
  endtask

  task automatic fillFlat(input logic [7:0] v);
    for (int i = 0; i < 64; i++) tile[i] = {v, v, v, v};
  endtask

  initial begin
    rst_n = 1'b0; inValid = 1'b0; inPixel = '0; outReady = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(inReady === 1'b1, "R1 inReady after reset", inReady, 1);
    check(outValid === 1'b0, "R1 outValid after reset", outValid, 0);

    fillFlat(8'h5A);
    runTile(0, "flat");

    // quad-constant grid at the signed 4-bit edges: +7 across, -8 down
    for (int i = 0; i < 64; i++)
      for (int ch = 0; ch < 4; ch++)
        tile[i][ch*8 +: 8] = 8'(100 + ch + 7*((i%8)/2) - 8*((i/8)/2));
    runTile(1, "grid edge");

    // quad-constant grid one past the edge
    for (int i = 0; i < 64; i++)
      for (int ch = 0; ch < 4; ch++)
        tile[i][ch*8 +: 8] = 8'(40 + 8*((i%8)/2));
    runTile(0, "grid over");

    // alternating +1/-1
    for (int i = 0; i < 64; i++)
      for (int ch = 0; ch < 4; ch++) tile[i][ch*8 +: 8] = 8'(50 + ch + ((i%8) & 1));
    runTile(1, "ripple");

    // +1 across, -2 down
    for (int i = 0; i < 64; i++)
      for (int ch = 0; ch < 4; ch++) tile[i][ch*8 +: 8] = 8'(10*ch + 30 + (i%8) - 2*(i/8));
    runTile(0, "quarter edge");

    // +2 across
    for (int i = 0; i < 64; i++)
      for (int ch = 0; ch < 4; ch++) tile[i][ch*8 +: 8] = 8'(20 + 2*(i%8));
    runTile(1, "step two");

    // +7 across, -8 down
    for (int i = 0; i < 64; i++)
      for (int ch = 0; ch < 4; ch++) tile[i][ch*8 +: 8] = 8'(64 + 5*ch + 7*(i%8) - 8*(i/8));
    runTile(0, "half edge");

    // noise
    for (int i = 0; i < 64; i++) begin
      noise = noise ^ (noise << 13); noise = noise ^ (noise >> 17); noise = noise ^ (noise << 5);
      tile[i] = noise;
    end
    runTile(1, "noise");

    // channel wraps 255 -> 0, still a +1 delta (R7)
    for (int i = 0; i < 64; i++)
      for (int ch = 0; ch < 4; ch++) tile[i][ch*8 +: 8] = 8'(250 + (i%8));
    runTile(0, "wrap");

    // identical rows: row start must use the pixel above (R7)
    for (int i = 0; i < 64; i++)
      for (int ch = 0; ch < 4; ch++) tile[i][ch*8 +: 8] = 8'(100 + (i%8));
    runTile(1, "row start");

    // lone disturbance swept over value, channel and position
    begin
      int posList [5] = '{0, 1, 8, 13, 63};
      for (int pi = 0; pi < 5; pi++)
        for (int ch = 0; ch < 4; ch++)
          for (int d = -9; d <= 9; d++) begin
            fillFlat(8'h80);
            tile[posList[pi]][ch*8 +: 8] = 8'(128 + d);
            runTile(((d + ch + pi) & 1) == 1, $sformatf("sweep p%0d c%0d d%0d", posList[pi], ch, d));
          end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule